// File: doc/BRIEF.md
# Random-Rotation Bus Line Scrambler

This block hides which physical wire of a constant-weight bus carries which encoded bit. All encoded lines of a transfer are rotated together by a pseudo-random amount before they reach the wires. These are the data lines plus the invert and balance lines, thirteen in total for an eight-bit payload. A descrambler at the receiving side undoes the rotation with the same amount, so the sender and the receiver both see plain words. The number of zeros on the wires is never changed, so the constant-weight property set up by the encoder survives the scrambling.

The rotation amount comes from a 16-bit Galois linear feedback shift register. Its seed is loaded from an external true-random source through a load strobe. The register steps once for every accepted transfer. A transfer is accepted on a clock edge where `xfer_valid` is high. One cycle later it appears on `line_out` together with the amount that was applied (`line_shift`), and the restored word appears on `recv_word` with `recv_valid` high. Until the next accepted transfer, the wires and the amount stay where they are.

Top module: `rot_bus_scrambler`

## Requirements
- R1: After reset, `line_out` is all zeros, `recv_valid` is low, and the generator holds the fallback state 16'hACE1. The first rotation amount is therefore (8'hE1 mod 13) = 4.
- R2: One cycle after an accepted transfer, `line_out` bit ((i + k) mod 13) equals bit i of the accepted word, where k is the rotation amount for that transfer (a left rotation by k).
- R3: In the cycle after an accepted transfer, `recv_valid` is high and `recv_word` equals the accepted word.
- R4: `line_out` has exactly as many ones, and so as many zeros, as the accepted word.
- R5: The rotation amount is the low 8 bits of the generator state reduced modulo 13, and always lies in 0 to 12. It is visible on `line_shift` for the word on `line_out`.
- R6: The generator steps exactly once per accepted transfer. Idle cycles do not step it.
- R7: A load strobe writes `seed_bits` into the generator. A seed of all zeros is replaced by 16'hACE1.
- R8: A load strobe wins over a step in the same cycle. A transfer accepted in that cycle still uses the amount from before the load. The next transfer uses the amount derived from the seed itself.
- R9: In a cycle after no accepted transfer, `recv_valid` is low and `line_out` and `line_shift` hold their previous values.
- R10: One step maps state s to (s >> 1), XORed with 16'hB400 when bit 0 of s was 1. This is the polynomial x^16+x^14+x^13+x^11+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load strobe for the generator seed |
| seed_bits | input | 16 | Seed from the true-random source |
| xfer_valid | input | 1 | Transfer accepted on this edge |
| xfer_word | input | 13 | Encoded word to send (data, invert, balance) |
| line_out | output | 13 | Rotated word on the bus wires |
| line_shift | output | 4 | Rotation amount applied to `line_out` |
| recv_word | output | 13 | Descrambled word for the receiver |
| recv_valid | output | 1 | `recv_word` holds a new transfer |

## Verification
The bench builds the block with its default values: 13 lines, a 16-bit generator with the 16'hB400 tap mask and the 16'hACE1 fallback, and 8 state bits reduced to the amount. With these values, a few dozen transfers reach most of the amounts from 0 to 12. That includes 0, where no rotation takes place, and 12, the largest wrap. The words at the edge of the range also appear: all zeros, all ones and a single one. Seeds are chosen so that the first transfer after a load produces a known amount, which tests the load priority, the zero-seed fallback and the rule that idle cycles leave the sequence untouched.

// File: rtl/rot_scr_pkg.sv
package rot_scr_pkg;
  typedef enum logic {ROT_LEFT = 1'b0, ROT_RIGHT = 1'b1} rot_dir_e;
endpackage

// File: rtl/rot_lfsr.sv
module rot_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         advance,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] galois_step(input logic [W-1:0] s);
    logic [W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  function automatic logic [W-1:0] seed_fix(input logic [W-1:0] s);
    return (s == '0) ? FALLBACK : s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= FALLBACK;
    else if (load)    state <= seed_fix(seed);
    else if (advance) state <= galois_step(state);
  end
endmodule

// File: rtl/rot_amount.sv
module rot_amount #(
  parameter int SRC_W = 16,
  parameter int USE_W = 8,
  parameter int LINES = 13,
  localparam int AMT_W = $clog2(LINES)
) (
  input  logic [SRC_W-1:0] src,
  output logic [AMT_W-1:0] amt
);
  function automatic logic [AMT_W-1:0] reduce(input logic [USE_W-1:0] v);
    int unsigned r;
    r = int'(v) % LINES;
    return AMT_W'(r);
  endfunction

  assign amt = reduce(src[USE_W-1:0]);
endmodule

// File: rtl/rot_shift.sv
module rot_shift
  import rot_scr_pkg::*;
#(
  parameter int LINES = 13,
  parameter rot_dir_e DIR = ROT_LEFT,
  localparam int AMT_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [LINES-1:0] dout
);
  function automatic logic [LINES-1:0] rotl(input logic [LINES-1:0] w, input logic [AMT_W-1:0] a);
    logic [LINES-1:0] o;
    o = '0;
    for (int i = 0; i < LINES; i++) o[(i + int'(a)) % LINES] = w[i];
    return o;
  endfunction

  function automatic logic [LINES-1:0] rotr(input logic [LINES-1:0] w, input logic [AMT_W-1:0] a);
    logic [LINES-1:0] o;
    o = '0;
    for (int i = 0; i < LINES; i++) o[i] = w[(i + int'(a)) % LINES];
    return o;
  endfunction

  generate
    if (DIR == ROT_LEFT) begin : g_left
      assign dout = rotl(din, amt);
    end else begin : g_right
      assign dout = rotr(din, amt);
    end
  endgenerate
endmodule

// File: rtl/rot_bus_scrambler.sv
module rot_bus_scrambler
  import rot_scr_pkg::*;
#(
  parameter int LINES = 13,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] FALLBACK = 16'hACE1,
  parameter int USE_W = 8,
  localparam int AMT_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_bits,
  input  logic              xfer_valid,
  input  logic [LINES-1:0]  xfer_word,
  output logic [LINES-1:0]  line_out,
  output logic [AMT_W-1:0]  line_shift,
  output logic              recv_valid,
  output logic [LINES-1:0]  recv_word
);
  logic [LFSR_W-1:0] lfsr_state;
  logic [AMT_W-1:0]  cur_amt;
  logic [LINES-1:0]  tx_rot;
  logic              step_evt;
  logic [LINES-1:0]  bus_q;
  logic [AMT_W-1:0]  amt_q;
  logic              vld_q;

  assign step_evt = xfer_valid && !seed_load;

  rot_lfsr #(.W(LFSR_W), .TAPS(TAPS), .FALLBACK(FALLBACK)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_bits),
    .advance(step_evt), .state(lfsr_state)
  );

  rot_amount #(.SRC_W(LFSR_W), .USE_W(USE_W), .LINES(LINES)) u_amt (
    .src(lfsr_state), .amt(cur_amt)
  );

  rot_shift #(.LINES(LINES), .DIR(ROT_LEFT)) u_scr (
    .din(xfer_word), .amt(cur_amt), .dout(tx_rot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q <= '0;
      amt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= xfer_valid;
      if (xfer_valid) begin
        bus_q <= tx_rot;
        amt_q <= cur_amt;
      end
    end
  end

  rot_shift #(.LINES(LINES), .DIR(ROT_RIGHT)) u_dscr (
    .din(bus_q), .amt(amt_q), .dout(recv_word)
  );

  assign line_out   = bus_q;
  assign line_shift = amt_q;
  assign recv_valid = vld_q;
endmodule

// File: rtl/rot_bus_scrambler_chk.sv
module rot_bus_scrambler_chk #(
  parameter int LINES = 13,
  parameter int LFSR_W = 16,
  localparam int AMT_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input logic [LFSR_W-1:0] seed_bits,
  input logic              xfer_valid,
  input logic [LINES-1:0]  xfer_word,
  input logic [LINES-1:0]  line_out,
  input logic [AMT_W-1:0]  line_shift,
  input logic              recv_valid,
  input logic [LINES-1:0]  recv_word,
  input logic [LFSR_W-1:0] lfsr_state
);
  assert_roundtrip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> (recv_valid && recv_word == $past(xfer_word)));

  assert_weight_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> ($countones(line_out) == $countones($past(xfer_word))));

  assert_amount_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_shift) < LINES);

  assert_idle_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && !seed_load) |=> $stable(lfsr_state));

  assert_seed_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (lfsr_state != '0));

  assert_seed_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_bits != '0) |=> (lfsr_state == $past(seed_bits)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> (!recv_valid && $stable(line_out) && $stable(line_shift)));
endmodule

bind rot_bus_scrambler rot_bus_scrambler_chk #(.LINES(LINES), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_bits(seed_bits),
  .xfer_valid(xfer_valid), .xfer_word(xfer_word), .line_out(line_out),
  .line_shift(line_shift), .recv_valid(recv_valid), .recv_word(recv_word),
  .lfsr_state(lfsr_state)
);

// File: tb/tb_rot_bus_scrambler.sv
module tb_rot_bus_scrambler;
  localparam int N = 13;
  localparam int VEC = 12;
  // each entry: {idle cycles after transfer [3:0], word [12:0]}
  localparam logic [16:0] VECS [VEC] = '{
    {4'd0, 13'h0001}, {4'd0, 13'h1FFF}, {4'd2, 13'h0000}, {4'd0, 13'h1000},
    {4'd1, 13'h0AAA}, {4'd0, 13'h1555}, {4'd3, 13'h00FF}, {4'd0, 13'h1F00},
    {4'd0, 13'h0123}, {4'd1, 13'h1ABC}, {4'd0, 13'h0F0F}, {4'd0, 13'h1001}
  };

  logic clk = 0, rst_n = 0, seed_load = 0, xfer_valid = 0;
  logic [15:0] seed_bits = '0;
  logic [N-1:0] xfer_word = '0;
  logic [N-1:0] line_out, recv_word;
  logic [3:0] line_shift;
  logic recv_valid;
  int errors = 0, checks = 0;
  logic [15:0] mstate;
  bit done = 0;

  always #5 clk = ~clk;

  rot_bus_scrambler dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_bits(seed_bits),
    .xfer_valid(xfer_valid), .xfer_word(xfer_word), .line_out(line_out),
    .line_shift(line_shift), .recv_valid(recv_valid), .recv_word(recv_word)
  );

  function automatic logic [15:0] m_next(input logic [15:0] s); // R10
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction
  function automatic int m_amt(input logic [15:0] s); // R5
    return int'(s & 16'h00FF) % 13;
  endfunction
  function automatic logic [N-1:0] m_rot(input logic [N-1:0] w, input int k); // R2
    logic [2*N-1:0] d;
    d = {13'b0, w} << k;
    return d[N-1:0] | d[2*N-1:N];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [N-1:0] w, input bit with_seed, input logic [15:0] sd);
    int k;
    logic [N-1:0] rw;
    k = m_amt(mstate);
    rw = m_rot(w, k);
    @(negedge clk);
    xfer_valid = 1; xfer_word = w; seed_load = with_seed; seed_bits = sd;
    @(negedge clk);
    xfer_valid = 0; seed_load = 0;
    chk("R2 line_out", 32'(line_out), 32'(rw));
    chk("R3 recv_word", {31'b0, recv_valid} << 16 | 32'(recv_word), 32'h10000 | 32'(w));
    chk("R4 ones", 32'($countones(line_out)), 32'($countones(w)));
    chk("R5 shift", 32'(line_shift), 32'(k));
    if (with_seed) mstate = (sd == 16'h0) ? 16'hACE1 : sd;
    else mstate = m_next(mstate);
  endtask

  task automatic idle(input int n);
    logic [N-1:0] lo;
    logic [3:0] ls;
    lo = line_out; ls = line_shift;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9 idle valid", 32'(recv_valid), 32'd0);
      chk("R9 idle hold", {16'(lo), 12'd0, ls}, {16'(line_out), 12'd0, line_shift});
    end
  endtask

  task automatic load_only(input logic [15:0] sd);
    @(negedge clk);
    seed_load = 1; seed_bits = sd;
    @(negedge clk);
    seed_load = 0;
    mstate = (sd == 16'h0) ? 16'hACE1 : sd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line_out", 32'(line_out), 32'd0);
    chk("R1 recv_valid", 32'(recv_valid), 32'd0);
    mstate = 16'hACE1;
    xfer(13'h0001, 0, 16'h0);       // R1 first amount is 4
    chk("R1 first shift", 32'(line_shift), 32'd4);

    // table walk: R2 R3 R4 R5, idle gaps check R6 R9
    for (int v = 0; v < VEC; v++) begin
      xfer(VECS[v][12:0], 0, 16'h0);
      idle(int'(VECS[v][16:13]));
    end

    // R7 explicit seed: 8'h0C -> amount 12, widest wrap
    load_only(16'h340C);
    xfer(13'h0003, 0, 16'h0);
    chk("R7 seed amount", 32'(line_shift), 32'd12);
    // R10 next amount follows one Galois step of the seed
    xfer(13'h1234, 0, 16'h0);
    chk("R10 step amount", 32'(line_shift), 32'(m_amt(m_next(16'h340C))));

    // R7 zero seed falls back to 16'hACE1 (amount 4)
    load_only(16'h0000);
    xfer(13'h0ABC, 0, 16'h0);
    chk("R7 zero seed", 32'(line_shift), 32'd4);

    // R8 load and transfer in one cycle: old amount used, seed next
    begin
      int old_k;
      old_k = m_amt(mstate);
      xfer(13'h0F0F, 1, 16'h5A1A);   // 8'h1A=26 -> amount 0
      chk("R8 old amount", 32'(line_shift), 32'(old_k));
      xfer(13'h1357, 0, 16'h0);
      chk("R8 seed amount", 32'(line_shift), 32'd0);
    end

    // R6 long idle then transfer uses a single step
    idle(7);
    xfer(13'h0808, 0, 16'h0);
    for (int r = 0; r < 30; r++) xfer(13'(r * 397 + 5), 0, 16'h0);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset valid", 32'(recv_valid), 32'd0);
    mstate = 16'hACE1;
    xfer(13'h1FFE, 0, 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule